// File: doc/BRIEF.md
# I2C Control Register Target

This block is a standard-mode I2C target. It holds a small bank of 8-bit control registers. An external master writes the registers in bursts and reads them back either from the current internal pointer or from an address it chooses. The block samples SCL and SDA with the system clock through a short synchronizer. It drives SDA only through an open-drain pull-low output. All register contents appear on a flat parallel bus, so the surrounding logic can use them directly.

The two strap inputs set the low bits of the device address. An internal pointer selects the register for each data byte and moves forward after every byte, in both directions. The pointer wraps from the last register back to the first. A register-address phase loads the pointer. A read with no address phase continues from where the previous access left off.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 0b00100 followed by `strap_a1` and then `strap_a0`. Bit 0 is the direction: 0 for write, 1 for read. Any other address is left unacknowledged, and the target stays silent until the next START.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. After a STOP the target releases SDA and ignores bytes until a new START.
- R3: In a write transfer, the byte after the address loads the register pointer from its low five bits. Every later byte is written to the register the pointer selects. The target acknowledges every received byte.
- R4: After each data byte, written or read, the pointer advances by one. The pointer moves from 06h to 00h.
- R5: A read transfer with no register-address phase returns the register at the pointer, which is the last accessed address plus one. The pointer is 00h after reset.
- R6: A random read works as a write of the address byte and the register address, then a repeated START and the address byte with the direction bit set. It returns the selected register and then the registers after it.
- R7: When the master does not acknowledge a read byte, the target stops driving SDA and sends no more data.
- R8: While `rst_n` is low, the registers hold 80h, 20h, 00h, 10h, 10h, 10h and 10h at addresses 00h to 06h. No bus transfer can change them during that time.
- R9: A write to a pointer value above 06h is acknowledged and then discarded. A read at such a pointer returns 00h.
- R10: `sda_pull_low` starts pulling only while SCL is low. It is released during the master's acknowledge bit of every read byte.
- R11: `reg_out[8*i+7:8*i]` holds register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull_low | output | 1 | Open-drain drive: 1 pulls SDA low |
| strap_a1 | input | 1 | Upper hard-wired device address bit |
| strap_a0 | input | 1 | Lower hard-wired device address bit |
| reg_out | output | 56 | All registers, register i in byte i |

## Verification
A pin change reaches the protocol logic three clocks later: two synchronizer stages and one edge-compare stage. `sda_pull_low` then changes on the next clock, so the target answers about four clocks after SCL falls. The bench holds SCL low for eight clocks before each rising edge and samples SDA in the middle of the high phase, so every acknowledge bit and data bit has settled when it is read. A register write lands one clock after the acknowledge-phase SCL fall. The bench reads `reg_out` only after the closing STOP, well past that point.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 5;
  localparam logic [4:0]  DEV_PREFIX = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REGA,
    ST_WDAT,
    ST_RDAT
  } link_state_t;

  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h20;
      2:       return 8'h00;
      default: return 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_pipe_q, scl_pipe_n;
  logic [DEPTH-1:0] sda_pipe_q, sda_pipe_n;
  logic scl_cur, scl_prev, sda_prev;

  always_comb begin
    scl_pipe_n = {scl_pipe_q[DEPTH-2:0], scl_in};
    sda_pipe_n = {sda_pipe_q[DEPTH-2:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_n;
      sda_pipe_q <= sda_pipe_n;
    end
  end

  assign scl_cur  = scl_pipe_q[STAGES-1];
  assign scl_prev = scl_pipe_q[STAGES];
  assign sda_s    = sda_pipe_q[STAGES-1];
  assign sda_prev = sda_pipe_q[STAGES];

  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_det = scl_cur & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [PTR_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [PTR_W-1:0]             rd_addr,
  output logic [BYTE_W-1:0]            rd_data,
  output logic [NUM_REGS*BYTE_W-1:0]   regs_flat
);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [BYTE_W-1:0] val_q;
    logic              hit;

    assign hit = wr_en && (wr_addr == PTR_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= reg_default(gi);
      end else if (hit) begin
        val_q <= wr_data;
      end
    end

    assign regs_flat[gi*BYTE_W +: BYTE_W] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == PTR_W'(i)) rd_data = regs_flat[i*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [1:0]        dev_pins,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              sda_drive
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  link_state_t       state_q, state_n;
  logic [2:0]        bit_cnt_q, bit_cnt_n;
  logic              full_q, full_n;
  logic              ackph_q, ackph_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic [BYTE_W-1:0] shreg_q, shreg_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              drive_q, drive_n;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == LAST_IDX) return '0;
    return p + PTR_W'(1);
  endfunction

  always_comb begin
    state_n   = state_q;
    bit_cnt_n = bit_cnt_q;
    full_n    = full_q;
    ackph_n   = ackph_q;
    rw_n      = rw_q;
    mack_n    = mack_q;
    shreg_n   = shreg_q;
    ptr_n     = ptr_q;
    drive_n   = drive_q;
    wr_en     = 1'b0;
    wr_addr   = ptr_q;
    wr_data   = shreg_q;

    if (stop_det) begin
      state_n = ST_IDLE;
      drive_n = 1'b0;
      ackph_n = 1'b0;
      full_n  = 1'b0;
    end else if (start_det) begin
      state_n   = ST_DEV;
      bit_cnt_n = '0;
      full_n    = 1'b0;
      ackph_n   = 1'b0;
      drive_n   = 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (ackph_q) begin
          if (state_q == ST_RDAT) mack_n = ~sda_s;
        end else begin
          if (state_q != ST_RDAT) shreg_n = {shreg_q[BYTE_W-2:0], sda_s};
          bit_cnt_n = bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) full_n = 1'b1;
        end
      end else if (scl_fall) begin
        if (full_q) begin
          full_n  = 1'b0;
          ackph_n = 1'b1;
          drive_n = 1'b0;
          case (state_q)
            ST_DEV: begin
              if (shreg_q[7:1] == {DEV_PREFIX, dev_pins}) begin
                drive_n = 1'b1;
                rw_n    = shreg_q[0];
              end else begin
                state_n = ST_IDLE;
                ackph_n = 1'b0;
              end
            end
            ST_REGA: begin
              drive_n = 1'b1;
              ptr_n   = shreg_q[PTR_W-1:0];
            end
            ST_WDAT: begin
              drive_n = 1'b1;
              wr_en   = 1'b1;
              ptr_n   = ptr_inc(ptr_q);
            end
            default: drive_n = 1'b0;
          endcase
        end else if (ackph_q) begin
          ackph_n   = 1'b0;
          bit_cnt_n = '0;
          drive_n   = 1'b0;
          case (state_q)
            ST_DEV: begin
              if (rw_q) begin
                state_n = ST_RDAT;
                shreg_n = rd_data;
                drive_n = ~rd_data[BYTE_W-1];
                ptr_n   = ptr_inc(ptr_q);
              end else begin
                state_n = ST_REGA;
              end
            end
            ST_REGA: state_n = ST_WDAT;
            ST_RDAT: begin
              if (mack_q) begin
                shreg_n = rd_data;
                drive_n = ~rd_data[BYTE_W-1];
                ptr_n   = ptr_inc(ptr_q);
              end else begin
                state_n = ST_IDLE;
              end
            end
            default: state_n = state_q;
          endcase
        end else if (state_q == ST_RDAT) begin
          drive_n = ~shreg_q[BYTE_W-2];
          shreg_n = {shreg_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      full_q    <= 1'b0;
      ackph_q   <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      drive_q   <= 1'b0;
    end else begin
      state_q   <= state_n;
      bit_cnt_q <= bit_cnt_n;
      full_q    <= full_n;
      ackph_q   <= ackph_n;
      rw_q      <= rw_n;
      mack_q    <= mack_n;
      shreg_q   <= shreg_n;
      ptr_q     <= ptr_n;
      drive_q   <= drive_n;
    end
  end

  assign ptr       = ptr_q;
  assign sda_drive = drive_q;

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_pull_low,
  input  logic                       strap_a1,
  input  logic                       strap_a0,
  output logic [NUM_REGS*BYTE_W-1:0] reg_out
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_link_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .dev_pins  ({strap_a1, strap_a0}),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .sda_drive (sda_pull_low)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .regs_flat (reg_out)
  );

endmodule

// File: rtl/i2c_regfile_checker.sv
module i2c_regfile_checker
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_in,
  input logic                       sda_pull_low,
  input logic                       stop_det,
  input logic                       wr_en,
  input logic [PTR_W-1:0]           wr_addr,
  input logic [BYTE_W-1:0]          wr_data,
  input logic [PTR_W-1:0]           ptr,
  input logic [NUM_REGS*BYTE_W-1:0] reg_out
);

  logic              last_valid_q;
  logic [PTR_W-1:0]  last_addr_q;
  logic [BYTE_W-1:0] last_data_q;
  logic [BYTE_W-1:0] byte_at;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_valid_q <= 1'b0;
      last_addr_q  <= '0;
      last_data_q  <= '0;
    end else begin
      last_valid_q <= wr_en && (wr_addr < PTR_W'(NUM_REGS));
      last_addr_q  <= wr_addr;
      last_data_q  <= wr_data;
    end
  end

  always_comb begin
    byte_at = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (last_addr_q == PTR_W'(i)) byte_at = reg_out[i*BYTE_W +: BYTE_W];
    end
  end

  a_r10_pull_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_in);

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_low);

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    last_valid_q |-> (byte_at == last_data_q));

  a_r9_high_write_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= PTR_W'(NUM_REGS))) |=> $stable(reg_out));

  a_r4_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == PTR_W'(NUM_REGS - 1))) |=> (ptr == '0));

endmodule

bind i2c_regfile_target i2c_regfile_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .scl_in       (scl_in),
  .sda_pull_low (sda_pull_low),
  .stop_det     (stop_det),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .ptr          (ptr),
  .reg_out      (reg_out)
);

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;

  localparam int HP = 8;
  localparam logic [7:0] DEV_WR = 8'h24;
  localparam logic [7:0] DEV_RD = 8'h25;
  localparam logic [55:0] DEFAULTS = 56'h10_10_10_10_00_20_80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_low;
  logic sda_line;
  logic [55:0] reg_out;
  logic [55:0] exp_regs;

  int tests = 0;
  int fails = 0;
  int r10_viol = 0;
  logic drive_prev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_low;

  i2c_regfile_target dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_m),
    .sda_in       (sda_line),
    .sda_pull_low (sda_pull_low),
    .strap_a1     (1'b1),
    .strap_a0     (1'b0),
    .reg_out      (reg_out)
  );

  always @(posedge clk) begin
    if (sda_pull_low && !drive_prev && scl_m) r10_viol++;
    drive_prev <= sda_pull_low;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HP);
      scl_m = 1'b1; tick(HP);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP/2);
    acked = (sda_line == 1'b0);
    tick(HP/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      scl_m = 1'b1; tick(HP/2);
      b[i] = sda_line;
      tick(HP/2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(HP);
    scl_m = 1'b1; tick(HP/2);
    check(sda_pull_low == 1'b0, "R10 release in master ack", 64'(sda_pull_low), 64'h0);
    tick(HP/2);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic put_byte(input logic [7:0] ra, input logic [7:0] d, input string req);
    bit a;
    bus_start();
    send_byte(DEV_WR, a); check(a, req, 64'(a), 64'h1);
    send_byte(ra, a);     check(a, req, 64'(a), 64'h1);
    send_byte(d, a);      check(a, req, 64'(a), 64'h1);
    bus_stop();
  endtask

  task automatic t_reset_hold();
    bit a;
    bus_start();
    send_byte(DEV_WR, a);
    check(!a, "R8 no ack in reset", 64'(a), 64'h0);
    send_byte(8'h03, a);
    send_byte(8'h55, a);
    bus_stop();
    check(reg_out == DEFAULTS, "R8 defaults held in reset", 64'(reg_out), 64'(DEFAULTS));
    rst_n = 1'b1;
    tick(5);
    check(reg_out == DEFAULTS, "R8 R11 defaults after reset", 64'(reg_out), 64'(DEFAULTS));
    exp_regs = DEFAULTS;
  endtask

  task automatic t_addr_mismatch();
    bit a;
    bus_start();
    send_byte(8'h26, a);
    check(!a, "R1 foreign address not acked", 64'(a), 64'h0);
    send_byte(8'h02, a);
    check(!a, "R1 silent until START", 64'(a), 64'h0);
    bus_stop();
    check(reg_out == exp_regs, "R1 no change", 64'(reg_out), 64'(exp_regs));
  endtask

  task automatic t_single_write();
    put_byte(8'h02, 8'hA5, "R3 ack on write");
    exp_regs[23:16] = 8'hA5;
    check(reg_out == exp_regs, "R3 R11 single write", 64'(reg_out), 64'(exp_regs));
  endtask

  task automatic t_burst_wrap();
    bit a;
    bus_start();
    send_byte(DEV_WR, a); check(a, "R3 ack dev", 64'(a), 64'h1);
    send_byte(8'h05, a);  check(a, "R3 ack reg addr", 64'(a), 64'h1);
    send_byte(8'h11, a);  check(a, "R4 ack data 5", 64'(a), 64'h1);
    send_byte(8'h22, a);  check(a, "R4 ack data 6", 64'(a), 64'h1);
    send_byte(8'h33, a);  check(a, "R4 ack data wrap", 64'(a), 64'h1);
    bus_stop();
    exp_regs[47:40] = 8'h11;
    exp_regs[55:48] = 8'h22;
    exp_regs[7:0]   = 8'h33;
    check(reg_out == exp_regs, "R4 burst wraps 06h to 00h", 64'(reg_out), 64'(exp_regs));
  endtask

  task automatic current_read(input logic [7:0] expv, input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(DEV_RD, a); check(a, req, 64'(a), 64'h1);
    recv_byte(1'b0, b);
    check(b == expv, req, 64'(b), 64'(expv));
    bus_stop();
  endtask

  task automatic t_current_read();
    current_read(8'h20, "R5 current read after burst");
    current_read(8'hA5, "R5 current read advances");
  endtask

  task automatic t_random_read();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(DEV_WR, a); check(a, "R6 dummy write dev", 64'(a), 64'h1);
    send_byte(8'h06, a);  check(a, "R6 dummy write addr", 64'(a), 64'h1);
    bus_start();
    send_byte(DEV_RD, a); check(a, "R6 read dev after Sr", 64'(a), 64'h1);
    recv_byte(1'b1, b);
    check(b == 8'h22, "R6 random read first", 64'(b), 64'h22);
    recv_byte(1'b0, b);
    check(b == 8'h33, "R4 read wraps to 00h", 64'(b), 64'h33);
    for (int i = 0; i < 3; i++) begin
      tick(HP);
      check(sda_pull_low == 1'b0 && sda_line == 1'b1, "R7 no drive after nack", 64'(sda_pull_low), 64'h0);
    end
    bus_stop();
    current_read(8'h20, "R5 read continues after nack");
  endtask

  task automatic t_high_addr();
    bit a;
    logic [7:0] b;
    put_byte(8'h09, 8'h77, "R9 high address acked");
    check(reg_out == exp_regs, "R9 high write discarded", 64'(reg_out), 64'(exp_regs));
    bus_start();
    send_byte(DEV_WR, a);
    send_byte(8'h09, a);
    bus_start();
    send_byte(DEV_RD, a); check(a, "R9 read dev", 64'(a), 64'h1);
    recv_byte(1'b0, b);
    check(b == 8'h00, "R9 high read is zero", 64'(b), 64'h0);
    bus_stop();
  endtask

  task automatic t_stop_idle();
    bit a;
    bus_start();
    send_byte(DEV_WR, a);
    send_byte(8'h04, a);
    bus_stop();
    check(reg_out == exp_regs, "R2 stop before data writes nothing", 64'(reg_out), 64'(exp_regs));
    send_byte(DEV_WR, a);
    check(!a, "R2 ignored without START", 64'(a), 64'h0);
    bus_stop();
    put_byte(8'h03, 8'h5C, "R2 new START accepted");
    exp_regs[31:24] = 8'h5C;
    check(reg_out == exp_regs, "R2 write after new START", 64'(reg_out), 64'(exp_regs));
  endtask

  initial begin
    exp_regs = DEFAULTS;
    tick(3);
    t_reset_hold();
    t_addr_mismatch();
    t_single_write();
    t_burst_wrap();
    t_current_read();
    t_random_read();
    t_high_addr();
    t_stop_idle();
    check(r10_viol == 0, "R10 pull starts only with SCL low", 64'(r10_viol), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule